// File: doc/BRIEF.md
# LCD Display RAM Address Controller

This block holds the dot pattern for a dot-matrix LCD and the address logic a host uses to fill it. The memory is organised as twelve byte-high pages plus a single-bit indicator row, 132 columns wide, for 97 rows in all. The host points at a page and a column with two independent set commands, then streams data bytes in or out. Each byte lies vertically, along the common-line direction, and each access moves the column one step to the right.

A second, independent scan port lets the display timing logic fetch one whole row of 132 segment bits per cycle. A direction flag chooses whether segment n shows column n or the mirrored column, so the driver can be placed on either side of the glass. Host traffic and scan reads use separate paths, so loading new data never disturbs the row being scanned out.

Top module: `lcd_dram_ctrl`

## Requirements
- R1: After reset, rd_data and scan_seg are 0, dir_flag is 0, and the page and column addresses are 0, so the first data write after reset lands at page 0, column 0.
- R2: A write at page p (0 to 11) and column c stores data bit b in row 8*p+b at column c; bit 0 is the top row of the page and bit 7 the bottom row.
- R3: Every data write or read strobe advances the column address by exactly one while it is below 131.
- R4: The column address stops at 131 and stays there on further accesses; reaching it never changes the page address.
- R5: Page 12 is the indicator row (row 96): a write there stores only data bit 0, and a read there returns bit 0 with bits 7 to 1 equal to 0.
- R6: Pages 13 to 15 hold no storage: writes there change no row, reads return 0, and the column still advances.
- R7: A read strobe returns, on rd_data in the cycle after the strobe, the byte at the address current at the strobe; rd_data otherwise holds its value.
- R8: With dir_flag 0, scan_seg[n] shows column n of the scanned row; with dir_flag 1 it shows column 131-n. A dir_set strobe loads dir_val into dir_flag on the next edge.
- R9: scan_seg shows, one cycle after scan_row is presented, the row content before any host write made in that same cycle; a row index above 96 gives all zeros.
- R10: A column-set value above 131 is ignored and the column address keeps its previous value.
- R11: When write and read strobes arrive together, the write is performed, rd_data holds its previous value, and the column advances once.
- R12: A page-set or column-set command in the same cycle as a data strobe takes effect for the following access; the strobe uses the address held before the command, and a valid column-set overrides the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_set | input | 1 | Load page address from page_val |
| page_val | input | 4 | Page value for page_set |
| col_set | input | 1 | Load column address from col_val |
| col_val | input | 8 | Column value for col_set |
| dir_set | input | 1 | Load direction flag from dir_val |
| dir_val | input | 1 | Direction value for dir_set |
| wr_en | input | 1 | Host data write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host data read strobe |
| rd_data | output | 8 | Host read byte, registered |
| scan_row | input | 7 | Row index for the display scan |
| scan_seg | output | 132 | Segment bits of the scanned row after direction mapping |
| dir_flag | output | 1 | Current column-to-segment direction |

## Verification
The bench drives the column into its last position with long write and read bursts and checks that it stops there rather than wrapping back to column 0 or stepping into the next page; a wrapping counter would overwrite column 0 and show up in the scanned rows. It writes all-ones bytes into the indicator page and the three empty pages, where a design that stored the upper bits would corrupt rows of page 11 or a neighbouring page, and one that failed to mask reads would return stray high bits. It scans every row under both directions, including indices past the last row, so a mirror off by one column or an unclamped row index shows up as shifted or stray segment bits. Simultaneous strobes, set commands arriving with a strobe, an out-of-range column set, and a scan of a row being written in the same cycle each have directed cases, followed by a random mix.

// File: rtl/lcd_dram_pkg.sv
package lcd_dram_pkg;
  parameter int unsigned NUM_COLS  = 132;
  parameter int unsigned NUM_PAGES = 12;
  parameter int unsigned BYTE_W    = 8;
endpackage

// File: rtl/lcd_addr_regs.sv
module lcd_addr_regs #(
  parameter int unsigned COLS   = 132,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_set,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              col_set,
  input  logic [COL_W-1:0]  col_val,
  input  logic              dir_set,
  input  logic              dir_val,
  input  logic              access,
  output logic [PAGE_W-1:0] page_q,
  output logic [COL_W-1:0]  col_q,
  output logic              dir_q
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [PAGE_W-1:0] page_d;
  logic [COL_W-1:0]  col_d;
  logic              dir_d;
  logic              col_ok;

  assign col_ok = (col_val <= LAST_COL);

  always_comb begin
    page_d = page_q;
    col_d  = col_q;
    dir_d  = dir_q;
    if (page_set) page_d = page_val;
    if (dir_set)  dir_d  = dir_val;
    if (col_set && col_ok) begin
      col_d = col_val;
    end else if (access && (col_q != LAST_COL)) begin
      col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      col_q  <= col_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/lcd_dot_store.sv
module lcd_dot_store #(
  parameter int unsigned COLS   = 132,
  parameter int unsigned PAGES  = 12,
  parameter int unsigned BW     = 8,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  input  logic [BW-1:0]     wr_data,
  output logic [BW-1:0]     rd_data,
  input  logic [ROW_W-1:0]  scan_row,
  output logic [COLS-1:0]   scan_bits
);
  localparam int unsigned ROWS = PAGES * BW + 1;
  localparam logic [PAGE_W-1:0] IND_PAGE = PAGE_W'(PAGES);

  logic [COLS-1:0] rows [ROWS];

  logic              page_ok;
  logic              is_ind;
  logic [ROW_W-1:0]  base;
  logic [BW-1:0]     bit_live;
  logic [BW-1:0]     byte_rd;

  assign page_ok = (page <= IND_PAGE);
  assign is_ind  = (page == IND_PAGE);
  assign base    = ROW_W'(page) * ROW_W'(BW);

  // lanes that have storage at the current page
  always_comb begin
    for (int b = 0; b < BW; b++) begin
      bit_live[b] = page_ok && ((b == 0) || !is_ind);
    end
  end

  always_comb begin
    for (int b = 0; b < BW; b++) begin
      if (bit_live[b]) byte_rd[b] = rows[int'(base) + b][col];
      else             byte_rd[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BW; b++) begin
        if (bit_live[b]) rows[int'(base) + b][col] <= wr_data[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= byte_rd;
  end

  assign scan_bits = (int'(scan_row) < ROWS) ? rows[scan_row] : '0;
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map #(
  parameter int unsigned COLS = 132
) (
  input  logic            flip,
  input  logic [COLS-1:0] row_bits,
  output logic [COLS-1:0] seg_bits
);
  for (genvar n = 0; n < COLS; n++) begin : g_seg
    assign seg_bits[n] = flip ? row_bits[COLS-1-n] : row_bits[n];
  end
endmodule

// File: rtl/lcd_dram_ctrl.sv
module lcd_dram_ctrl
  import lcd_dram_pkg::*;
#(
  parameter int unsigned COLS   = NUM_COLS,
  parameter int unsigned PAGES  = NUM_PAGES,
  parameter int unsigned BW     = BYTE_W,
  parameter int unsigned PAGE_W = $clog2(PAGES + 1),
  parameter int unsigned COL_W  = $clog2(COLS),
  parameter int unsigned ROW_W  = $clog2(PAGES * BW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_set,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              col_set,
  input  logic [COL_W-1:0]  col_val,
  input  logic              dir_set,
  input  logic              dir_val,
  input  logic              wr_en,
  input  logic [BW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [BW-1:0]     rd_data,
  input  logic [ROW_W-1:0]  scan_row,
  output logic [COLS-1:0]   scan_seg,
  output logic              dir_flag
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              dir_q;
  logic              rd_go;
  logic [COLS-1:0]   raw_row;
  logic [COLS-1:0]   mapped_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // write has priority over a read in the same cycle
  assign rd_go = rd_en && !wr_en;

  lcd_addr_regs #(.COLS(COLS), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .page_set (page_set),
    .page_val (page_val),
    .col_set  (col_set),
    .col_val  (col_val),
    .dir_set  (dir_set),
    .dir_val  (dir_val),
    .access   (wr_en || rd_en),
    .page_q   (page_q),
    .col_q    (col_q),
    .dir_q    (dir_q)
  );

  lcd_dot_store #(.COLS(COLS), .PAGES(PAGES), .BW(BW), .PAGE_W(PAGE_W),
                  .COL_W(COL_W), .ROW_W(ROW_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .rd_en     (rd_go),
    .page      (page_q),
    .col       (col_q),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .scan_row  (scan_row),
    .scan_bits (raw_row)
  );

  lcd_seg_map #(.COLS(COLS)) u_map (
    .flip     (dir_q),
    .row_bits (raw_row),
    .seg_bits (mapped_row)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) scan_seg <= '0;
    else             scan_seg <= mapped_row;
  end

  assign dir_flag = dir_q;
endmodule

// File: rtl/lcd_dram_ctrl_chk.sv
module lcd_dram_ctrl_chk #(
  parameter int unsigned COLS   = 132,
  parameter int unsigned PAGES  = 12,
  parameter int unsigned BW     = 8,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ROW_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_set,
  input logic              col_set,
  input logic              wr_en,
  input logic              rd_en,
  input logic [PAGE_W-1:0] page_q,
  input logic [COL_W-1:0]  col_q,
  input logic [BW-1:0]     rd_data,
  input logic [ROW_W-1:0]  scan_row,
  input logic [COLS-1:0]   scan_seg
);
  localparam logic [COL_W-1:0]  LAST = COL_W'(COLS - 1);
  localparam logic [PAGE_W-1:0] IND  = PAGE_W'(PAGES);
  localparam int unsigned       ROWS = PAGES * BW + 1;

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !col_set && col_q != LAST) |=> col_q == $past(col_q) + 1'b1);

  assert_col_hold_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == LAST && !col_set) |=> col_q == LAST);

  assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !page_set |=> page_q == $past(page_q));

  assert_col_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST);

  assert_ind_read_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && page_q == IND) |=> rd_data[BW-1:1] == '0);

  assert_empty_page_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && page_q > IND) |=> rd_data == '0);

  assert_no_read_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(rd_data));

  assert_scan_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scan_row) >= ROWS) |=> scan_seg == '0);
endmodule

bind lcd_dram_ctrl lcd_dram_ctrl_chk #(
  .COLS(COLS), .PAGES(PAGES), .BW(BW), .PAGE_W(PAGE_W), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .page_set (page_set),
  .col_set  (col_set),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .page_q   (page_q),
  .col_q    (col_q),
  .rd_data  (rd_data),
  .scan_row (scan_row),
  .scan_seg (scan_seg)
);

// File: tb/lcd_dram_ctrl_test.sv
`timescale 1ns/1ps
module lcd_dram_ctrl_test;
  localparam int NC = 132;
  localparam int NR = 97;

  logic         clk;
  logic         rst_n;
  logic         page_set, col_set, dir_set, dir_val, wr_en, rd_en;
  logic [3:0]   page_val;
  logic [7:0]   col_val, wr_data;
  logic [7:0]   rd_data;
  logic [6:0]   scan_row;
  logic [131:0] scan_seg;
  logic         dir_flag;

  lcd_dram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .page_set(page_set), .page_val(page_val),
    .col_set(col_set), .col_val(col_val), .dir_set(dir_set), .dir_val(dir_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .scan_row(scan_row), .scan_seg(scan_seg), .dir_flag(dir_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state
  bit       mdl [NR][NC];
  int       m_page, m_col, m_dir;
  logic [7:0]   m_rd;
  logic [131:0] m_scan;
  int       vectors, misses;
  string    tag;
  bit       done;

  function automatic logic [7:0] ref_byte(int p, int c);
    logic [7:0] r = '0;
    if (p < 12) for (int b = 0; b < 8; b++) r[b] = mdl[p*8+b][c];
    else if (p == 12) r[0] = mdl[96][c];
    return r;
  endfunction

  task automatic cyc();
    int r;
    r = int'(scan_row);
    for (int n = 0; n < NC; n++)
      m_scan[n] = (r < NR) ? mdl[r][(m_dir != 0) ? (NC-1-n) : n] : 1'b0;
    if (rd_en && !wr_en) m_rd = ref_byte(m_page, m_col);
    if (wr_en) begin
      if (m_page < 12) for (int b = 0; b < 8; b++) mdl[m_page*8+b][m_col] = wr_data[b];
      else if (m_page == 12) mdl[96][m_col] = wr_data[0];
    end
    if (dir_set) m_dir = dir_val;
    if (col_set && col_val <= 8'd131) m_col = col_val;
    else if ((wr_en || rd_en) && m_col < NC-1) m_col++;
    if (page_set) m_page = page_val;
    @(posedge clk);
    #2;
    vectors++;
    if (rd_data !== m_rd) begin
      misses++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, m_rd);
    end
    if (scan_seg !== m_scan) begin
      misses++;
      $display("FAIL %s scan_seg actual %h expected %h", tag, scan_seg, m_scan);
    end
    if (dir_flag !== m_dir[0]) begin
      misses++;
      $display("FAIL %s dir_flag actual %b expected %b", tag, dir_flag, m_dir[0]);
    end
  endtask

  task automatic idle();
    page_set = 0; col_set = 0; dir_set = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic set_addr(int p, int c);
    idle(); page_set = 1; page_val = 4'(p); col_set = 1; col_val = 8'(c); cyc(); idle();
  endtask

  task automatic set_dir(int d);
    idle(); dir_set = 1; dir_val = d[0]; cyc(); idle();
  endtask

  task automatic wr(logic [7:0] d);
    idle(); wr_en = 1; wr_data = d; cyc(); idle();
  endtask

  task automatic rd();
    idle(); rd_en = 1; cyc(); idle();
  endtask

  initial begin
    #500000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired during %s", tag);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    vectors = 0; misses = 0; done = 0; tag = "R1";
    m_page = 0; m_col = 0; m_dir = 0; m_rd = '0;
    rst_n = 0; idle(); page_val = 0; col_val = 0; dir_val = 0; wr_data = 0;
    scan_row = 7'd127;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state at the ports
    vectors++;
    if (rd_data !== 8'h00 || scan_seg !== '0 || dir_flag !== 1'b0) begin
      misses++;
      $display("FAIL R1 reset outputs actual %h/%h/%b expected 0/0/0", rd_data, scan_seg, dir_flag);
    end

    // R1/R2/R3: fill page 0 with no set command, relying on reset address
    tag = "R1 R2 R3 fill";
    for (int c = 0; c < NC; c++) wr(8'($urandom));
    for (int p = 1; p <= 12; p++) begin
      set_addr(p, 0);
      for (int c = 0; c < NC; c++) wr(8'($urandom));
    end

    // R8 R9: scan all rows under both directions, including out of range
    tag = "R8 R9 scan";
    for (int r = 0; r < 100; r++) begin scan_row = 7'(r); cyc(); end
    set_dir(1);
    for (int r = 0; r < 100; r++) begin scan_row = 7'(r); cyc(); end
    scan_row = 7'd127; cyc();
    set_dir(0);

    // R7 R3: streaming reads
    tag = "R7 R3 read stream";
    set_addr(3, 10);
    for (int i = 0; i < 6; i++) rd();
    cyc();

    // R4: saturation by writes and reads, page unchanged
    tag = "R4 saturate";
    set_addr(5, 128);
    for (int i = 0; i < 6; i++) wr(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) rd();
    scan_row = 7'd40; cyc();
    set_addr(5, 0); rd(); rd();
    set_addr(6, 0); rd();

    // R5: indicator page masking
    tag = "R5 indicator";
    set_addr(12, 7); wr(8'hFF); wr(8'hFE);
    set_addr(12, 7); rd(); rd();
    scan_row = 7'd96; cyc();
    set_addr(11, 7); rd(); rd();

    // R6: pages without storage
    tag = "R6 empty pages";
    for (int p = 13; p < 16; p++) begin
      set_addr(p, 20); wr(8'hFF); wr(8'h55); rd(); rd();
    end
    set_addr(11, 20); rd(); rd(); set_addr(0, 20); rd(); rd();

    // R10: out-of-range column set ignored
    tag = "R10 col set range";
    set_addr(2, 50);
    idle(); col_set = 1; col_val = 8'd200; cyc(); idle();
    wr(8'h3C);
    set_addr(2, 50); rd(); rd();

    // R11: simultaneous strobes
    tag = "R11 wr rd together";
    set_addr(4, 60);
    idle(); wr_en = 1; rd_en = 1; wr_data = 8'h96; cyc(); idle();
    rd(); set_addr(4, 60); rd();

    // R12: set commands alongside a strobe
    tag = "R12 set with strobe";
    set_addr(1, 30);
    idle(); wr_en = 1; wr_data = 8'h81; col_set = 1; col_val = 8'd90; page_set = 1; page_val = 4'd7; cyc(); idle();
    rd(); set_addr(1, 30); rd(); rd();

    // R9: scan of a row written in the same cycle shows old data
    tag = "R9 scan during write";
    set_addr(8, 0); scan_row = 7'd64;
    for (int i = 0; i < 5; i++) wr(8'($urandom));
    cyc();

    // random mix
    tag = "R2 R3 R8 random";
    for (int i = 0; i < 600; i++) begin
      idle();
      case ($urandom % 8)
        0: begin page_set = 1; page_val = 4'($urandom); end
        1: begin col_set = 1; col_val = 8'($urandom % 140); end
        2: begin dir_set = 1; dir_val = 1'($urandom); end
        3, 4: begin wr_en = 1; wr_data = 8'($urandom); end
        5, 6: rd_en = 1;
        default: begin wr_en = 1; rd_en = 1; wr_data = 8'($urandom); end
      endcase
      scan_row = 7'($urandom % 100);
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule